// File: doc/BRIEF.md
# Trace Sample Word Packer

This block sits between a trace port sampler and the trace buffer memory. Each accepted sample carries a 3-bit pipeline status, a packet field and a sync flag, plus a trigger marker. The block formats each sample into a lane and gathers lanes into 32-bit words. One word goes to the buffer as soon as it is full. The lane width and the number of lanes per word follow the configured trace port width:

- narrow 4-bit packets: three lanes per word
- 8-bit packets: two lanes per word
- 16-bit packets: one lane per word

A sample flagged as a trigger is re-encoded. Its status field takes a fixed trigger code, and its real status moves into the bottom of the packet field. When capture stops partway through a word, a stop pulse pushes out the partial word. The unfilled lanes of that word are zero. A drained flag tells the capture controller that nothing is left inside the block. Port configurations the buffer cannot store are flagged, and samples are refused while such a configuration is selected.

Top module: `trace_word_packer`

## Requirements
- R1: With `cfg_width`=0 (4-bit packets) three samples fill a word, in 8-bit lanes at bits 7:0, 15:8 and 23:16, first sample lowest. A lane holds status in bits 2:0, packet bits 3:0 in bits 6:3 and sync in bit 7. Packet input bits above bit 3 have no effect.
- R2: With `cfg_width`=1 (8-bit packets) two samples fill a word, in 12-bit lanes at bits 11:0 and 23:12. A lane holds status in bits 2:0, packet bits 7:0 in bits 10:3 and sync in bit 11.
- R3: With `cfg_width`=2 (16-bit packets) each sample makes one word: status in bits 2:0, packet in bits 18:3, sync in bit 19.
- R4: A sample accepted with `s_trigger`=1 has status field 3'b110 (6). The low three bits of its packet field hold the sample's real status. The packet bits above those three pass through unchanged.
- R5: Every bit of an emitted word above the last lane of the configured width is zero (bits 31:24 for widths 0 and 1, bits 31:20 for width 2).
- R6: `w_valid` is high for exactly one cycle per word. It rises in the cycle after the edge that accepts the word's last sample, and no earlier.
- R7: A `cap_stop` pulse with lanes pending emits the partial word in the next cycle, with empty lanes zero. A sample accepted at the same edge is included as the next lane. A `cap_stop` pulse with nothing pending and no sample emits nothing.
- R8: `cfg_err` is high, and `s_ready` low, when `cfg_muxed`=1, or `cfg_width`=3, or `cfg_demux`=1 with `cfg_width`≠1. Samples offered then are not taken and never appear in a word.
- R9: `drained` is high exactly when no lane is pending and `w_valid` is low.
- R10: After reset `w_valid`=0 and `drained`=1. With a legal configuration `s_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_width | input | 2 | Port width: 0=4-bit, 1=8-bit, 2=16-bit, 3=reserved |
| cfg_muxed | input | 1 | Multiplexed port mode selected (unsupported) |
| cfg_demux | input | 1 | Demultiplexed port mode selected |
| cfg_err | output | 1 | Configuration cannot be stored |
| s_valid | input | 1 | Sample offered |
| s_ready | output | 1 | Sample can be accepted |
| s_status | input | 3 | Pipeline status of the sample |
| s_packet | input | 16 | Packet field; low bits used in narrower modes |
| s_sync | input | 1 | Sync flag of the sample |
| s_trigger | input | 1 | Sample is the trigger cycle |
| cap_stop | input | 1 | Capture stop pulse; flushes a partial word |
| w_valid | output | 1 | Word valid toward the buffer |
| w_data | output | 32 | Packed buffer word |
| drained | output | 1 | No partial word and no word in the output register |

## Verification
The bench drives every width with samples whose sync, high packet bits and trigger differ. A lane placed at the wrong offset, or a trigger that overwrites the high packet bits, shows up directly in the word. It checks that `w_valid` is still low one sample before a word completes and falls again after one cycle. An early or stretched strobe would duplicate or split words in the buffer. Stop pulses are applied with one lane pending, with a sample at the same edge, and with nothing pending. A design that drops the concurrent sample, or emits an empty word, fails there. Illegal configurations are applied with samples offered. A leak is caught by `drained` and by the content of the next word.

// File: rtl/tpk_pkg.sv
package tpk_pkg;

   typedef enum logic [1:0] {
      PW_NARROW = 2'd0,
      PW_MID    = 2'd1,
      PW_WIDE   = 2'd2,
      PW_RSVD   = 2'd3
   } port_width_e;

   localparam int unsigned NUM_WIDTHS = 3;

endpackage

// File: rtl/tpk_lane_fmt.sv
module tpk_lane_fmt #(
   parameter int unsigned STAT_W    = 3,
   parameter int unsigned PKT_W     = 4,
   parameter logic [2:0]  TRIG_CODE = 3'd6,
   localparam int unsigned LANE_W   = STAT_W + PKT_W + 1
) (
   input  logic [STAT_W-1:0] status,
   input  logic [PKT_W-1:0]  packet,
   input  logic              sync,
   input  logic              trig,
   output logic [LANE_W-1:0] lane
);

   if (PKT_W <= STAT_W) begin : g_bad_pkt
      $error("packet field must be wider than status field");
   end

   logic [STAT_W-1:0] st_f;
   logic [PKT_W-1:0]  pk_f;

   always_comb begin
      if (trig) begin
         st_f = STAT_W'(TRIG_CODE);
         pk_f = {packet[PKT_W-1:STAT_W], status};
      end else begin
         st_f = status;
         pk_f = packet;
      end
      lane = {sync, pk_f, st_f};
   end

endmodule

// File: rtl/tpk_assembler.sv
module tpk_assembler #(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned MAX_LANES = 3,
   localparam int unsigned CNT_W    = $clog2(MAX_LANES + 1),
   localparam int unsigned SH_W     = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [WORD_W-1:0] lane,
   input  logic [SH_W-1:0]   lane_w,
   input  logic [CNT_W-1:0]  last_idx,
   input  logic              flush,
   output logic              busy,
   output logic              w_valid,
   output logic [WORD_W-1:0] w_data
);

   logic [CNT_W-1:0]  cnt;
   logic [SH_W-1:0]   off;
   logic [WORD_W-1:0] acc;
   logic [WORD_W-1:0] merged;
   logic              close_word;

   always_comb begin
      merged     = push ? (acc | (lane << off)) : acc;
      close_word = (push && (cnt == last_idx)) || (flush && (push || (cnt != '0)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         off     <= '0;
         acc     <= '0;
         w_valid <= 1'b0;
         w_data  <= '0;
      end else begin
         w_valid <= 1'b0;
         if (close_word) begin
            w_data  <= merged;
            w_valid <= 1'b1;
            acc     <= '0;
            cnt     <= '0;
            off     <= '0;
         end else if (push) begin
            acc <= merged;
            cnt <= cnt + 1'b1;
            off <= off + lane_w;
         end
      end
   end

   assign busy = (cnt != '0);

   a_r6_last_lane_emits: assert property (@(posedge clk) disable iff (!rst_n)
      (push && (cnt == last_idx)) |=> w_valid);

   a_r7_stop_flushes: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && (busy || push)) |=> w_valid);

   a_r7_idle_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !busy && !push) |=> !w_valid);

   a_r9_empty_after_word: assert property (@(posedge clk) disable iff (!rst_n)
      w_valid |-> (cnt == '0));

endmodule

// File: rtl/trace_word_packer.sv
module trace_word_packer
   import tpk_pkg::*;
#(
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned STAT_W     = 3,
   parameter int unsigned PKT_NARROW = 4,
   parameter int unsigned PKT_MID    = 8,
   parameter int unsigned PKT_WIDE   = 16,
   parameter int unsigned LN_NARROW  = 3,
   parameter int unsigned LN_MID     = 2,
   parameter int unsigned LN_WIDE    = 1,
   parameter logic [2:0]  TRIG_CODE  = 3'd6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          cfg_width,
   input  logic                cfg_muxed,
   input  logic                cfg_demux,
   output logic                cfg_err,
   input  logic                s_valid,
   output logic                s_ready,
   input  logic [STAT_W-1:0]   s_status,
   input  logic [PKT_WIDE-1:0] s_packet,
   input  logic                s_sync,
   input  logic                s_trigger,
   input  logic                cap_stop,
   output logic                w_valid,
   output logic [WORD_W-1:0]   w_data,
   output logic                drained
);

   localparam int unsigned LW_NARROW = STAT_W + PKT_NARROW + 1;
   localparam int unsigned LW_MID    = STAT_W + PKT_MID + 1;
   localparam int unsigned LW_WIDE   = STAT_W + PKT_WIDE + 1;
   localparam int unsigned MAX_LANES = (LN_NARROW > LN_MID) ?
                                       ((LN_NARROW > LN_WIDE) ? LN_NARROW : LN_WIDE) :
                                       ((LN_MID > LN_WIDE) ? LN_MID : LN_WIDE);
   localparam int unsigned CNT_W     = $clog2(MAX_LANES + 1);
   localparam int unsigned SH_W      = $clog2(WORD_W + 1);

   if (LN_NARROW * LW_NARROW > WORD_W) begin : g_chk_narrow
      $error("narrow lanes do not fit in a word");
   end
   if (LN_MID * LW_MID > WORD_W) begin : g_chk_mid
      $error("mid lanes do not fit in a word");
   end
   if (LN_WIDE * LW_WIDE > WORD_W) begin : g_chk_wide
      $error("wide lanes do not fit in a word");
   end
   if (!(PKT_NARROW < PKT_MID && PKT_MID < PKT_WIDE)) begin : g_chk_order
      $error("packet widths must increase");
   end

   port_width_e       pw;
   logic              legal;
   logic              push;
   logic              busy;
   logic [WORD_W-1:0] fmt_lane [NUM_WIDTHS];
   logic [WORD_W-1:0] sel_lane;
   logic [SH_W-1:0]   sel_lw;
   logic [CNT_W-1:0]  sel_last;

   assign pw      = port_width_e'(cfg_width);
   assign legal   = !cfg_muxed && (pw != PW_RSVD) && (!cfg_demux || (pw == PW_MID));
   assign cfg_err = !legal;
   assign s_ready = legal;
   assign push    = s_valid && legal;

   for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_fmt
      localparam int unsigned PW_G = (g == 0) ? PKT_NARROW : ((g == 1) ? PKT_MID : PKT_WIDE);
      localparam int unsigned LW_G = STAT_W + PW_G + 1;
      logic [LW_G-1:0] lane_g;

      tpk_lane_fmt #(
         .STAT_W   (STAT_W),
         .PKT_W    (PW_G),
         .TRIG_CODE(TRIG_CODE)
      ) u_fmt (
         .status(s_status),
         .packet(s_packet[PW_G-1:0]),
         .sync  (s_sync),
         .trig  (s_trigger),
         .lane  (lane_g)
      );

      if (LW_G < WORD_W) begin : g_pad
         assign fmt_lane[g] = {{(WORD_W - LW_G){1'b0}}, lane_g};
      end else begin : g_nopad
         assign fmt_lane[g] = lane_g;
      end
   end

   always_comb begin
      sel_lane = '0;
      sel_lw   = '0;
      sel_last = '0;
      unique case (pw)
         PW_NARROW: begin
            sel_lane = fmt_lane[0];
            sel_lw   = SH_W'(LW_NARROW);
            sel_last = CNT_W'(LN_NARROW - 1);
         end
         PW_MID: begin
            sel_lane = fmt_lane[1];
            sel_lw   = SH_W'(LW_MID);
            sel_last = CNT_W'(LN_MID - 1);
         end
         PW_WIDE: begin
            sel_lane = fmt_lane[2];
            sel_lw   = SH_W'(LW_WIDE);
            sel_last = CNT_W'(LN_WIDE - 1);
         end
         default: ;
      endcase
   end

   tpk_assembler #(
      .WORD_W   (WORD_W),
      .MAX_LANES(MAX_LANES)
   ) u_asm (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (push),
      .lane    (sel_lane),
      .lane_w  (sel_lw),
      .last_idx(sel_last),
      .flush   (cap_stop),
      .busy    (busy),
      .w_valid (w_valid),
      .w_data  (w_data)
   );

   assign drained = !busy && !w_valid;

   logic [SH_W:0] used_bits;
   always_comb begin
      case (pw)
         PW_NARROW: used_bits = (SH_W+1)'(LN_NARROW * LW_NARROW);
         PW_MID:    used_bits = (SH_W+1)'(LN_MID * LW_MID);
         default:   used_bits = (SH_W+1)'(LN_WIDE * LW_WIDE);
      endcase
   end

   a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (w_valid && legal) |-> ((w_data >> used_bits) == '0));

   a_r8_no_take_when_illegal: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err && !busy && !cap_stop) |=> !w_valid);

endmodule

// File: tb/sim_trace_word_packer.sv
module sim_trace_word_packer;

   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [1:0]  mode;
      logic [20:0] s0;
      logic [20:0] s1;
      logic [20:0] s2;
      logic [31:0] exp;
   } vec_t;

   // sample encoding: {trigger, sync, status[2:0], packet[15:0]}
   localparam vec_t TBL [6] = '{
      '{2'd0, 21'h1000A,  21'hF0003,  21'h2000F, 32'h007A9F51},  // R1
      '{2'd0, 21'h150008, 21'h0FFF0,  21'hB0001, 32'h008B006E},  // R1 R4
      '{2'd1, 21'hC00C3,  21'h2005A,  21'h0,     32'h002D2E1C},  // R2
      '{2'd1, 21'h000FF,  21'h1900F0, 21'h0,     32'h00F8E7F8},  // R2 R4
      '{2'd2, 21'hFBEEF,  21'h0,      21'h0,     32'h000DF77F},  // R3
      '{2'd2, 21'h121234, 21'h0,      21'h0,     32'h00009196}   // R3 R4
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_width = 2'd0;
   logic        cfg_muxed = 1'b0;
   logic        cfg_demux = 1'b0;
   logic        cfg_err;
   logic        s_valid = 1'b0;
   logic        s_ready;
   logic [2:0]  s_status = '0;
   logic [15:0] s_packet = '0;
   logic        s_sync = 1'b0;
   logic        s_trigger = 1'b0;
   logic        cap_stop = 1'b0;
   logic        w_valid;
   logic [31:0] w_data;
   logic        drained;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trace_word_packer u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_width(cfg_width), .cfg_muxed(cfg_muxed), .cfg_demux(cfg_demux),
      .cfg_err(cfg_err),
      .s_valid(s_valid), .s_ready(s_ready), .s_status(s_status),
      .s_packet(s_packet), .s_sync(s_sync), .s_trigger(s_trigger),
      .cap_stop(cap_stop),
      .w_valid(w_valid), .w_data(w_data), .drained(drained)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // called at a negedge; the sample is taken at the following posedge
   task automatic drive(input logic [20:0] smp);
      s_valid   = 1'b1;
      s_trigger = smp[20];
      s_sync    = smp[19];
      s_status  = smp[18:16];
      s_packet  = smp[15:0];
   endtask

   task automatic idle_in();
      s_valid = 1'b0; s_trigger = 1'b0; s_sync = 1'b0;
      s_status = '0; s_packet = '0; cap_stop = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 w_valid at reset", 32'(w_valid), 32'd0);
      chk("R10 drained at reset", 32'(drained), 32'd1);
      chk("R10 s_ready at reset", 32'(s_ready), 32'd1);
      rst_n = 1'b1;

      // table walk: R1 R2 R3 R4 R5 R6
      for (int i = 0; i < 6; i++) begin
         logic [20:0] smp [3];
         int nl;
         smp[0] = TBL[i].s0; smp[1] = TBL[i].s1; smp[2] = TBL[i].s2;
         nl = (TBL[i].mode == 2'd0) ? 3 : ((TBL[i].mode == 2'd1) ? 2 : 1);
         @(negedge clk);
         cfg_width = TBL[i].mode;
         for (int k = 0; k < nl; k++) begin
            @(negedge clk);
            if (k > 0) chk("R6 no early word", 32'(w_valid), 32'd0);
            drive(smp[k]);
         end
         @(negedge clk);
         idle_in();
         chk("R6 word strobe", 32'(w_valid), 32'd1);
         chk("R1 R2 R3 R4 R5 word content", w_data, TBL[i].exp);
         @(negedge clk);
         chk("R6 strobe one cycle", 32'(w_valid), 32'd0);
         chk("R9 drained after word", 32'(drained), 32'd1);
      end

      // R7: partial word in 4-bit mode, one lane pending
      @(negedge clk);
      cfg_width = 2'd0;
      @(negedge clk);
      drive(21'h1000A);
      @(negedge clk);
      idle_in();
      chk("R9 not drained with lane pending", 32'(drained), 32'd0);
      cap_stop = 1'b1;
      @(negedge clk);
      cap_stop = 1'b0;
      chk("R7 flush strobe", 32'(w_valid), 32'd1);
      chk("R7 flush zero-filled", w_data, 32'h00000051);
      chk("R9 not drained while word out", 32'(drained), 32'd0);
      @(negedge clk);
      chk("R9 drained after flush", 32'(drained), 32'd1);

      // R7: stop together with a sample, 8-bit mode
      cfg_width = 2'd1;
      @(negedge clk);
      drive(21'hC00C3);
      cap_stop = 1'b1;
      @(negedge clk);
      idle_in();
      chk("R7 stop with sample strobe", 32'(w_valid), 32'd1);
      chk("R7 stop with sample content", w_data, 32'h00000E1C);

      // R7: stop with nothing pending
      @(negedge clk);
      cap_stop = 1'b1;
      @(negedge clk);
      cap_stop = 1'b0;
      chk("R7 idle stop no word", 32'(w_valid), 32'd0);
      chk("R7 idle stop drained", 32'(drained), 32'd1);

      // R8: illegal configurations
      cfg_muxed = 1'b1;
      #1;
      chk("R8 muxed err", 32'(cfg_err), 32'd1);
      chk("R8 muxed not ready", 32'(s_ready), 32'd0);
      drive(21'hFBEEF);
      @(negedge clk);
      idle_in();
      chk("R8 muxed sample ignored drained", 32'(drained), 32'd1);
      cfg_muxed = 1'b0;
      cfg_demux = 1'b1;
      cfg_width = 2'd0;
      #1;
      chk("R8 demux narrow err", 32'(cfg_err), 32'd1);
      drive(21'hF0003);
      @(negedge clk);
      idle_in();
      chk("R8 demux narrow drained", 32'(drained), 32'd1);
      cfg_width = 2'd3;
      cfg_demux = 1'b0;
      #1;
      chk("R8 reserved width err", 32'(cfg_err), 32'd1);
      cfg_width = 2'd1;
      cfg_demux = 1'b1;
      #1;
      chk("R8 demux mid legal", 32'(cfg_err), 32'd0);
      chk("R8 demux mid ready", 32'(s_ready), 32'd1);
      // ignored samples must not have entered lane 0
      drive(21'hC00C3);
      @(negedge clk);
      drive(21'h2005A);
      @(negedge clk);
      idle_in();
      chk("R8 next word clean", w_data, 32'h002D2E1C);
      chk("R6 strobe after legal word", 32'(w_valid), 32'd1);
      @(negedge clk);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule